// File: doc/BRIEF.md
# Atomic Test-and-Set Bus Engine

This block performs one indivisible test-and-set on a single byte of memory for a processor-side requester. The requester presents a byte address and the current extend flag. The engine then claims a simple memory bus and raises a lock. It reads the byte, writes it back with its most significant bit forced high, and releases the lock. While the lock is held no other master may use the bus, so the byte can serve as a semaphore shared by several processors.

Condition flags come from the byte as it was read, before it is modified. They are reported in a five-bit condition word. A bus error in either phase aborts the operation. The lock is released, a write that has not yet been issued is skipped, and completion is signalled together with an error indication. Address calculation, instruction decode and bus arbitration lie outside the block. The engine only asks for the bus and waits for a grant.

Top module: `tas_engine`

## Requirements
- R1: The operand is always one byte at the address captured when the request is accepted, and that address is presented on `bus_addr` for both the read and the write phase.
- R2: `ccr` bit 3 (negative) is set when bit 7 of the byte as read is 1, and is cleared otherwise.
- R3: `ccr` bit 2 (zero) is set when the byte as read equals 0x00, and is cleared otherwise.
- R4: `ccr` bits 1 (overflow) and 0 (carry) are always 0. `ccr` bit 4 (extend) carries the `req_x` value captured at acceptance, unchanged.
- R5: The byte written back equals the byte as read OR 0x80: bit 7 is forced to 1 and bits 6 to 0 are kept.
- R6: `bus_lock` rises in the cycle after acceptance, before any read is issued. It stays high through the read and write phases and is low from the cycle after the write acknowledge (or an error) onward.
- R7: After acceptance `bus_req` is held until the operation ends. No `bus_valid` appears before `bus_gnt`. Exactly one read (`bus_we`=0) and then one write (`bus_we`=1) are issued, the write starting in the cycle after the read acknowledge.
- R8: `done` is a single-cycle pulse in the cycle after the final bus response, and the engine is idle in the cycle after it.
- R9: `ccr` is loaded only in the clock edge that captures the read data. It holds its value until the next successful read capture.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. A `req_valid` that arrives while `busy` is high is ignored and causes no bus access.
- R11: An error on the read phase skips the write, drops the lock, raises `err` together with `done`, and leaves `ccr` unchanged.
- R12: An error on the write phase ends the operation with `err` and `done`, drops the lock, and keeps the `ccr` value computed from the read.
- R13: While reset is active, `busy`, `done`, `err`, `bus_req`, `bus_lock`, `bus_valid` and `bus_we` are 0 and `ccr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_addr | input | ADDR_W | Byte address of the semaphore |
| req_x | input | 1 | Current extend flag, passed to `ccr` bit 4 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Operation aborted by a bus error, valid with `done` |
| ccr | output | 5 | Condition word {X, N, Z, V, C} |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_lock | output | 1 | Bus lock, held across read and write |
| bus_valid | output | 1 | Transfer command valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer completed |
| bus_err | input | 1 | Transfer failed |

## Verification
The bench builds the engine with `ADDR_W` set to 5, so a 32-byte model memory covers the whole address space. With the full space covered, every write the engine makes lands in a location the bench can read back. Grant delays of 0 to 3 cycles and acknowledge latencies of 0 to 3 cycles vary how long the lock is held. Repeated test-and-set on the same byte covers both an already-set and a clear semaphore. Injected errors on each phase, and requests made while busy, reach the abort and ignore paths.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CCR_W  = 5;
  localparam int unsigned CC_C   = 0;
  localparam int unsigned CC_V   = 1;
  localparam int unsigned CC_Z   = 2;
  localparam int unsigned CC_N   = 3;
  localparam int unsigned CC_X   = 4;
  localparam logic [BYTE_W-1:0] SET_MASK = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARB  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_FIN  = 3'd4
  } tas_st_e;
endpackage

// File: rtl/tas_ctrl.sv
module tas_ctrl
  import tas_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    bus_gnt,
  input  logic    bus_ack,
  input  logic    bus_err,
  output tas_st_e st,
  output logic    accept,
  output logic    rd_cap,
  output logic    fail_q
);
  tas_st_e st_d;
  logic    fail_set;
  logic    fail_en;
  logic    fail_d;

  always_comb begin
    st_d = st;
    unique case (st)
      ST_IDLE: if (req_valid) st_d = ST_ARB;
      ST_ARB:  if (bus_gnt) st_d = ST_RD;
      ST_RD: begin
        if (bus_err)      st_d = ST_FIN;
        else if (bus_ack) st_d = ST_WR;
      end
      ST_WR:   if (bus_err || bus_ack) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    accept   = (st == ST_IDLE) && req_valid;
    rd_cap   = (st == ST_RD) && bus_ack && !bus_err;
    fail_set = ((st == ST_RD) || (st == ST_WR)) && bus_err;
    fail_en  = accept || fail_set;
    fail_d   = fail_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fail_q <= 1'b0;
    else if (fail_en) fail_q <= fail_d;
  end

  a_r8_fin_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FIN) |=> (st == ST_IDLE));

  a_r11_rd_err_skips_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && bus_err) |=> (st == ST_FIN));

  a_r7_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR) |-> ($past(st) == ST_RD || $past(st) == ST_WR));

  a_r7_no_read_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && $past(st) != ST_RD) |-> $past(bus_gnt));
endmodule

// File: rtl/tas_ccr.sv
module tas_ccr
  import tas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_cap,
  input  logic              req_x,
  input  logic [BYTE_W-1:0] rdata,
  output logic [CCR_W-1:0]  ccr,
  output logic [BYTE_W-1:0] wdata
);
  logic              x_q;
  logic [BYTE_W-1:0] rd_q;
  logic [CCR_W-1:0]  ccr_q;
  logic [CCR_W-1:0]  ccr_d;

  always_comb begin
    ccr_d       = '0;
    ccr_d[CC_X] = x_q;
    ccr_d[CC_N] = rdata[BYTE_W-1];
    ccr_d[CC_Z] = (rdata == '0);
    ccr_d[CC_V] = 1'b0;
    ccr_d[CC_C] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      x_q <= 1'b0;
    else if (accept) x_q <= req_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      ccr_q <= '0;
    end else if (rd_cap) begin
      rd_q  <= rdata;
      ccr_q <= ccr_d;
    end
  end

  assign ccr   = ccr_q;
  assign wdata = rd_q | SET_MASK;

  a_r2_neg_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |=> (ccr[CC_N] == $past(rdata[BYTE_W-1])));

  a_r3_zero_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |=> (ccr[CC_Z] == ($past(rdata) == '0)));

  a_r9_ccr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cap |=> $stable(ccr));

  a_r5_wdata_sets_msb: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |=> (wdata == ($past(rdata) | SET_MASK)));
endmodule

// File: rtl/tas_engine.sv
module tas_engine
  import tas_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_x,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [CCR_W-1:0]  ccr,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_lock,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err
);
  tas_st_e           st;
  logic              accept;
  logic              rd_cap;
  logic              fail_q;
  logic [ADDR_W-1:0] addr_q;

  tas_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .bus_gnt   (bus_gnt),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .st        (st),
    .accept    (accept),
    .rd_cap    (rd_cap),
    .fail_q    (fail_q)
  );

  tas_ccr u_ccr (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .rd_cap (rd_cap),
    .req_x  (req_x),
    .rdata  (bus_rdata),
    .ccr    (ccr),
    .wdata  (bus_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  always_comb begin
    busy      = (st != ST_IDLE);
    bus_lock  = (st == ST_ARB) || (st == ST_RD) || (st == ST_WR);
    bus_req   = bus_lock;
    bus_valid = (st == ST_RD) || (st == ST_WR);
    bus_we    = (st == ST_WR);
    done      = (st == ST_FIN);
    err       = done && fail_q;
    bus_addr  = addr_q;
  end

  a_r6_valid_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_lock && bus_req));

  a_r6_lock_drops_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && (bus_ack || bus_err)) |=> !bus_lock);

  a_r10_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r11_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r8_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && $past(bus_valid)) |-> $stable(bus_addr));
endmodule

// File: tb/sim_tas_engine.sv
`timescale 1ns/1ps
module sim_tas_engine;
  localparam int AW = 5;
  localparam int MEMN = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_x;
  logic          busy, done, err;
  logic [4:0]    ccr;
  logic          bus_req, bus_gnt, bus_lock, bus_valid, bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          bus_ack, bus_err;

  tas_engine #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_x(req_x), .busy(busy), .done(done), .err(err), .ccr(ccr),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_lock(bus_lock),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_err(bus_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory and responder
  logic [7:0] mem [MEMN];
  int gnt_dly = 0, ack_dly = 0, gcnt = 0, acnt = 0;
  bit inj_rd = 0, inj_wr = 0;

  always @(negedge clk) begin
    if (bus_req) begin
      bus_gnt <= (gcnt >= gnt_dly);
      gcnt = gcnt + 1;
    end else begin
      bus_gnt <= 1'b0;
      gcnt = 0;
    end
    if (bus_valid) begin
      if (acnt >= ack_dly) begin
        acnt = 0;
        bus_rdata <= mem[bus_addr];
        if ((bus_we && inj_wr) || (!bus_we && inj_rd)) begin
          bus_err <= 1'b1;
          bus_ack <= 1'b0;
        end else begin
          bus_err <= 1'b0;
          bus_ack <= 1'b1;
          if (bus_we) mem[bus_addr] = bus_wdata;
        end
      end else begin
        acnt = acnt + 1;
        bus_ack <= 1'b0;
        bus_err <= 1'b0;
      end
    end else begin
      acnt = 0;
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
    end
  end

  // behavioural reference, stepped on every clock
  int         ph;
  logic [AW-1:0] m_addr;
  logic       m_x, m_err;
  logic [7:0] m_rd;
  logic [4:0] m_ccr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 0; m_addr <= '0; m_x <= 0; m_err <= 0; m_rd <= 0; m_ccr <= 0;
    end else begin
      case (ph)
        0: if (req_valid) begin ph <= 1; m_addr <= req_addr; m_x <= req_x; m_err <= 0; end
        1: if (bus_gnt) ph <= 2;
        2: if (bus_err) begin m_err <= 1; ph <= 4; end
           else if (bus_ack) begin
             m_rd  <= bus_rdata;
             m_ccr <= {m_x, bus_rdata[7], bus_rdata == 8'h00, 1'b0, 1'b0};
             ph    <= 3;
           end
        3: if (bus_err) begin m_err <= 1; ph <= 4; end
           else if (bus_ack) ph <= 4;
        default: ph <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (ph != 0), "R10 busy", busy, ph != 0);
      chk(bus_lock == (ph >= 1 && ph <= 3), "R6 lock", bus_lock, ph >= 1 && ph <= 3);
      chk(bus_req == (ph >= 1 && ph <= 3), "R7 bus_req", bus_req, ph >= 1 && ph <= 3);
      chk(bus_valid == (ph == 2 || ph == 3), "R7 bus_valid", bus_valid, ph == 2 || ph == 3);
      chk(bus_we == (ph == 3), "R7 bus_we", bus_we, ph == 3);
      chk(done == (ph == 4), "R8 done", done, ph == 4);
      chk(err == (ph == 4 && m_err), "R11 err", err, ph == 4 && m_err);
      chk(ccr == m_ccr, "R9 ccr", ccr, m_ccr);
      if (bus_valid) chk(bus_addr == m_addr, "R1 addr", bus_addr, m_addr);
      if (ph == 3) chk(bus_wdata == (m_rd | 8'h80), "R5 wdata", bus_wdata, m_rd | 8'h80);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  logic [4:0] exp_ccr;

  task automatic run_op(input logic [AW-1:0] a, input bit x, input int gd, input int ad,
                        input bit erd, input bit ewr, input bit poke, input logic [AW-1:0] pa);
    logic [7:0] old_v, old_p;
    bit seen_done, seen_err;
    old_v = mem[a];
    old_p = mem[pa];
    seen_done = 0; seen_err = 0;
    gnt_dly = gd; ack_dly = ad; inj_rd = erd; inj_wr = ewr;
    req_valid = 1'b1; req_addr = a; req_x = x;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (poke && i == 2) begin
        req_valid = 1'b1; req_addr = pa; req_x = ~x;
      end else req_valid = 1'b0;
      if (done) begin seen_done = 1; seen_err = err; break; end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(seen_done, "R8 done seen", seen_done, 1);
    chk(seen_err == (erd || ewr), erd ? "R11 err flag" : "R12 err flag", seen_err, erd || ewr);
    if (erd) chk(mem[a] == old_v, "R11 no write", mem[a], old_v);
    else if (ewr) chk(mem[a] == old_v, "R12 no write", mem[a], old_v);
    else chk(mem[a] == (old_v | 8'h80), "R5 memory", mem[a], old_v | 8'h80);
    if (!erd) exp_ccr = {x, old_v[7], old_v == 8'h00, 1'b0, 1'b0};
    chk(ccr[3] == exp_ccr[3], "R2 negative", ccr[3], exp_ccr[3]);
    chk(ccr[2] == exp_ccr[2], "R3 zero", ccr[2], exp_ccr[2]);
    chk(ccr[4] == exp_ccr[4] && ccr[1:0] == 2'b00, "R4 X/V/C", ccr, exp_ccr);
    chk(!busy && !bus_lock, "R6 released", {busy, bus_lock}, 0);
    if (poke) chk(mem[pa] == old_p, "R10 ignored request", mem[pa], old_p);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = '0; req_x = 0;
    bus_gnt = 0; bus_ack = 0; bus_err = 0; bus_rdata = 0;
    exp_ccr = 0;
    for (int i = 0; i < MEMN; i++) mem[i] = 8'(i * 37 + 11);
    mem[3] = 8'h00; mem[7] = 8'h80; mem[9] = 8'h7F; mem[12] = 8'hA5; mem[20] = 8'hFF;
    repeat (3) @(negedge clk);
    chk({busy, done, err, bus_req, bus_lock, bus_valid, bus_we} == 7'd0 && ccr == 5'd0,
        "R13 reset state", {busy, done, err, bus_req, bus_lock, bus_valid, bus_we, ccr}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    run_op(5'd3,  1'b0, 0, 0, 0, 0, 0, 5'd0);
    run_op(5'd7,  1'b1, 2, 1, 0, 0, 1, 5'd9);
    run_op(5'd9,  1'b0, 1, 3, 0, 0, 0, 5'd0);
    run_op(5'd3,  1'b1, 0, 0, 0, 0, 0, 5'd0);
    run_op(5'd12, 1'b0, 3, 0, 1, 0, 0, 5'd0);
    run_op(5'd20, 1'b1, 0, 2, 0, 1, 0, 5'd0);
    run_op(5'd12, 1'b1, 0, 0, 0, 0, 1, 5'd20);
    run_op(5'd25, 1'b0, 2, 2, 0, 0, 1, 5'd26);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule